// File: doc/BRIEF.md
# Priority-ordered prefetch request queue

This block holds prefetch candidates that a prefetch address generator has produced but that the cache has not yet issued. Each candidate carries a block number, a secure-space bit and a signed priority. The queue keeps its entries in priority order and shows the head entry on an issue port once that entry has aged by a programmable number of cycles. A consumer takes the head with a valid/ready handshake.

When the same block is offered again while it is still queued, the queue does not store a second copy. It counts the repeat, and if the new priority is higher it lifts the stored entry toward the head. When a new candidate arrives and every slot is in use, the queue throws out the oldest entry of its lowest priority level to make room. Three counters report repeats, evictions and issued entries. Address generation, translation and the cache side all live outside this block.

Top module: `prefetch_prio_queue`

## Requirements
- R1: While `rst_n` is low at a clock edge, the queue empties. After that edge `iss_valid` is 0 and all three counters read 0.
- R2: Entries are held in descending signed priority. A new entry goes behind every queued entry whose priority is greater than or equal to its own, so entries of equal priority leave in arrival order.
- R3: An entry taken in at the edge of cycle k gets ready time k + `cfg_latency`, counted in cycles. `iss_valid` is 1 in cycle t exactly when the queue is non-empty and t is at or past the head's ready time. The earliest issue is therefore max(`cfg_latency`, 1) cycles after the insert.
- R4: When `iss_valid` and `iss_ready` are both 1 at an edge, the head entry leaves the queue and `cnt_issue` increases by 1.
- R5: When `cfg_filter_en` is 1 and an insert matches a queued entry on both `ins_blk` and `ins_secure`, no new entry is stored and `cnt_hit` increases by 1. A match with a priority that is equal or lower leaves the stored entry unchanged.
- R6: When such a match carries a priority strictly greater than the stored one, the stored entry takes the new priority. It also moves ahead of every entry of lower priority, stays behind entries of equal or higher priority, and keeps its original ready time.
- R7: When `cfg_filter_en` is 0, a repeated block is stored as a separate entry and `cnt_hit` does not change.
- R8: A new entry that arrives while all DEPTH slots are occupied first removes the oldest entry of the lowest priority level present, and `cnt_evict` increases by 1. The new entry is then placed by R2, even when its priority is below every queued priority.
- R9: An issue and an insert in the same cycle are both carried out, and the issue acts first. A full queue that issues in that cycle therefore does not evict, and the entry being issued cannot count as a duplicate of the insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_filter_en | input | 1 | 1 enables merging of repeated blocks |
| cfg_latency | input | LAT_W | Cycles from insert until an entry may issue |
| ins_valid | input | 1 | Candidate offered this cycle |
| ins_blk | input | BLK_W | Block number of the candidate |
| ins_secure | input | 1 | Secure-space bit of the candidate |
| ins_prio | input | PRIO_W | Signed priority of the candidate |
| iss_valid | output | 1 | Head entry present and ready |
| iss_ready | input | 1 | Consumer takes the head this cycle |
| iss_blk | output | BLK_W | Head block number |
| iss_secure | output | 1 | Head secure-space bit |
| iss_prio | output | PRIO_W | Head priority |
| cnt_hit | output | CNT_W | Count of merged repeats |
| cnt_evict | output | CNT_W | Count of entries evicted by a full queue |
| cnt_issue | output | CNT_W | Count of entries issued |

## Verification
Mixed priorities sent through a queue with zero latency separate descending order from plain FIFO order. A run of equal priorities shows whether ties stay in arrival order. Repeats with lower, equal and higher priority, each sent with the filter on and then with it off, separate merging and promotion from duplicate storage. A queue filled with a staircase of priorities and then offered further candidates shows which victim is chosen. Mixing those inserts with same-cycle issues shows whether the issue is ordered ahead of the insert. A long stretch of random traffic over a few blocks, with latency and filter changed along the way, is compared every cycle against a behavioural list model.

// File: rtl/pq_pkg.sv
// Package pq_pkg
// Shared types for the priority prefetch queue.
// Assumes: nothing beyond the encoding below.
package pq_pkg;

    // What an incoming candidate does to the queue this cycle
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,   // no candidate
        ACT_NEW     = 2'd1,   // stored as a fresh entry
        ACT_PROMOTE = 2'd2,   // repeat that lifts a stored entry
        ACT_HIT     = 2'd3    // repeat that changes nothing
    } ins_act_e;

endpackage

// File: rtl/pq_scan.sv
// Module pq_scan
// Looks through a compacted entry array for a duplicate of a key.
// Also finds the eviction victim: the first (oldest) entry whose priority
// equals the tail priority.
// Assumes: valid entries occupy indices 0..n-1 in descending priority,
// so the victim index is the number of entries above the tail priority.
module pq_scan #(
    parameter int DEPTH  = 32,
    parameter int BLK_W  = 26,
    parameter int PRIO_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]         vld,
    input  logic [BLK_W-1:0]         blk  [DEPTH],
    input  logic                     sec  [DEPTH],
    input  logic signed [PRIO_W-1:0] prio [DEPTH],
    input  logic [BLK_W-1:0]         key_blk,
    input  logic                     key_sec,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx,
    output logic [IDX_W-1:0]         victim_idx
);

    // Lowest matching index wins (at most one match when filtering)
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld[i] && blk[i] == key_blk && sec[i] == key_sec) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // Count entries above the tail priority to find the oldest lowest entry
    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && prio[i] > prio[DEPTH-1])
                victim_idx = victim_idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/pq_rank.sv
// Module pq_rank
// Returns the slot where an entry of a given priority must be placed:
// the number of valid entries with priority greater than or equal to it.
// Assumes: the array is compacted and sorted, so that count is the slot.
module pq_rank #(
    parameter int DEPTH  = 32,
    parameter int PRIO_W = 8,
    localparam int POS_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]         vld,
    input  logic signed [PRIO_W-1:0] prio [DEPTH],
    input  logic signed [PRIO_W-1:0] key_prio,
    output logic [POS_W-1:0]         pos
);

    // Count entries that stay ahead of the key
    always_comb begin
        pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && prio[i] >= key_prio)
                pos = pos + POS_W'(1);
        end
    end

endmodule

// File: rtl/pq_shift_out.sv
// Module pq_shift_out
// Removes one word from a compacted array by shifting every later word
// one slot toward index 0. The last slot becomes empty.
// Assumes: idx names a valid slot whenever en is high.
module pq_shift_out #(
    parameter int DEPTH = 32,
    parameter int EW    = 48,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [EW-1:0]    w_in  [DEPTH],
    input  logic [DEPTH-1:0] v_in,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [EW-1:0]    w_out [DEPTH],
    output logic [DEPTH-1:0] v_out
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Each slot at or past idx takes its successor
        if (i < DEPTH - 1) begin : g_mid
            assign w_out[i] = (en && IDX_W'(i) >= idx) ? w_in[i+1] : w_in[i];
            assign v_out[i] = (en && IDX_W'(i) >= idx) ? v_in[i+1] : v_in[i];
        end else begin : g_last
            assign w_out[i] = (en && IDX_W'(i) >= idx) ? '0   : w_in[i];
            assign v_out[i] = (en && IDX_W'(i) >= idx) ? 1'b0 : v_in[i];
        end
    end

endmodule

// File: rtl/pq_shift_in.sv
// Module pq_shift_in
// Places one word at slot pos of a compacted array and moves every word
// from pos onward one slot toward the tail.
// Assumes: the last slot is empty whenever en is high (the caller has
// already made room), so nothing is pushed out.
module pq_shift_in #(
    parameter int DEPTH = 32,
    parameter int EW    = 48,
    localparam int POS_W = $clog2(DEPTH + 1)
) (
    input  logic [EW-1:0]    w_in  [DEPTH],
    input  logic [DEPTH-1:0] v_in,
    input  logic             en,
    input  logic [POS_W-1:0] pos,
    input  logic [EW-1:0]    word,
    output logic [EW-1:0]    w_out [DEPTH],
    output logic [DEPTH-1:0] v_out
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Slot ahead of pos keeps, slot pos takes the word, later ones shift
        if (i == 0) begin : g_head
            assign w_out[i] = (en && pos == POS_W'(0)) ? word : w_in[i];
            assign v_out[i] = (en && pos == POS_W'(0)) ? 1'b1 : v_in[i];
        end else begin : g_rest
            assign w_out[i] = (!en || POS_W'(i) < pos) ? w_in[i] :
                              (POS_W'(i) == pos)       ? word    : w_in[i-1];
            assign v_out[i] = (!en || POS_W'(i) < pos) ? v_in[i] :
                              (POS_W'(i) == pos)       ? 1'b1    : v_in[i-1];
        end
    end

endmodule

// File: rtl/prefetch_prio_queue.sv
// Module prefetch_prio_queue
// Bounded queue of prefetch candidates kept in descending signed priority,
// FIFO within a level. Each cycle runs three combinational stages on the
// stored array: (1) an issue removes the head, (2) a promotion or an
// eviction removes one more entry, (3) the incoming or promoted entry is
// placed at its rank. The result is registered.
// Assumes: synchronous active-low reset; ins_blk is already a block number;
// the cycle counter wraps modulo 2**TIME_W and cfg_latency stays well below
// 2**(TIME_W-1).
module prefetch_prio_queue
    import pq_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int BLK_W  = 26,
    parameter int PRIO_W = 8,
    parameter int TIME_W = 32,
    parameter int LAT_W  = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_filter_en,
    input  logic [LAT_W-1:0]  cfg_latency,
    input  logic              ins_valid,
    input  logic [BLK_W-1:0]  ins_blk,
    input  logic              ins_secure,
    input  logic [PRIO_W-1:0] ins_prio,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [BLK_W-1:0]  iss_blk,
    output logic              iss_secure,
    output logic [PRIO_W-1:0] iss_prio,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_evict,
    output logic [CNT_W-1:0]  cnt_issue
);

    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int POS_W   = $clog2(DEPTH + 1);
    localparam int BLK_LO  = 0;
    localparam int SEC_LO  = BLK_W;
    localparam int PRIO_LO = BLK_W + 1;
    localparam int RDY_LO  = BLK_W + 1 + PRIO_W;
    localparam int EW      = BLK_W + 1 + PRIO_W + TIME_W;

    // Stored state
    logic [EW-1:0]     q_w [DEPTH];
    logic [DEPTH-1:0]  q_v;
    logic [TIME_W-1:0] now;

    // Stage outputs
    logic [EW-1:0]     w1 [DEPTH];
    logic [DEPTH-1:0]  v1;
    logic [EW-1:0]     w2 [DEPTH];
    logic [DEPTH-1:0]  v2;
    logic [EW-1:0]     w3 [DEPTH];
    logic [DEPTH-1:0]  v3;

    // Field views of stage 1 and stage 2
    logic [BLK_W-1:0]         blk1  [DEPTH];
    logic                     sec1  [DEPTH];
    logic signed [PRIO_W-1:0] prio1 [DEPTH];
    logic [TIME_W-1:0]        rdy1  [DEPTH];
    logic signed [PRIO_W-1:0] prio2 [DEPTH];

    logic              pop;
    logic [TIME_W-1:0] head_age;
    logic              scan_hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  victim_idx;
    logic [POS_W-1:0]  ins_pos;
    logic              evict;
    logic              rm_en;
    logic [IDX_W-1:0]  rm_idx;
    logic              ins_en;
    logic [EW-1:0]     ins_word;
    ins_act_e          act;

    // Head presentation: ready once now has reached the stored ready time
    assign head_age   = now - q_w[0][RDY_LO +: TIME_W];
    assign iss_valid  = q_v[0] && !head_age[TIME_W-1];
    assign iss_blk    = q_w[0][BLK_LO +: BLK_W];
    assign iss_secure = q_w[0][SEC_LO];
    assign iss_prio   = q_w[0][PRIO_LO +: PRIO_W];
    assign pop        = iss_valid && iss_ready;

    // Stage 1: the issue leaves first
    pq_shift_out #(.DEPTH(DEPTH), .EW(EW)) u_pop (
        .w_in (q_w), .v_in (q_v), .en (pop), .idx ('0),
        .w_out(w1),  .v_out(v1)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_view
        assign blk1[i]  = w1[i][BLK_LO +: BLK_W];
        assign sec1[i]  = w1[i][SEC_LO];
        assign prio1[i] = w1[i][PRIO_LO +: PRIO_W];
        assign rdy1[i]  = w1[i][RDY_LO +: TIME_W];
        assign prio2[i] = w2[i][PRIO_LO +: PRIO_W];
    end

    pq_scan #(.DEPTH(DEPTH), .BLK_W(BLK_W), .PRIO_W(PRIO_W)) u_scan (
        .vld       (v1),
        .blk       (blk1),
        .sec       (sec1),
        .prio      (prio1),
        .key_blk   (ins_blk),
        .key_sec   (ins_secure),
        .hit       (scan_hit),
        .hit_idx   (hit_idx),
        .victim_idx(victim_idx)
    );

    // Classify the incoming candidate against the post-issue array
    always_comb begin
        if (!ins_valid)
            act = ACT_NONE;
        else if (!(cfg_filter_en && scan_hit))
            act = ACT_NEW;
        else if ($signed(ins_prio) > prio1[hit_idx])
            act = ACT_PROMOTE;
        else
            act = ACT_HIT;
    end

    assign evict  = (act == ACT_NEW) && v1[DEPTH-1];
    assign rm_en  = (act == ACT_PROMOTE) || evict;
    assign rm_idx = (act == ACT_PROMOTE) ? hit_idx : victim_idx;
    assign ins_en = (act == ACT_PROMOTE) || (act == ACT_NEW);

    // Stage 2: the promoted entry or the eviction victim leaves
    pq_shift_out #(.DEPTH(DEPTH), .EW(EW)) u_remove (
        .w_in (w1), .v_in (v1), .en (rm_en), .idx (rm_idx),
        .w_out(w2), .v_out(v2)
    );

    // Word to place: a promotion keeps its ready time, a new entry ages from now
    always_comb begin
        if (act == ACT_PROMOTE)
            ins_word = {rdy1[hit_idx], ins_prio, ins_secure, ins_blk};
        else
            ins_word = {now + TIME_W'(cfg_latency), ins_prio, ins_secure, ins_blk};
    end

    pq_rank #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_rank (
        .vld     (v2),
        .prio    (prio2),
        .key_prio($signed(ins_prio)),
        .pos     (ins_pos)
    );

    // Stage 3: place the word behind all entries of equal or higher priority
    pq_shift_in #(.DEPTH(DEPTH), .EW(EW)) u_place (
        .w_in (w2), .v_in (v2), .en (ins_en), .pos (ins_pos), .word (ins_word),
        .w_out(w3), .v_out(v3)
    );

    // Register the next array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_v <= '0;
            for (int i = 0; i < DEPTH; i++) q_w[i] <= '0;
        end else begin
            q_v <= v3;
            q_w <= w3;
        end
    end

    // Free-running cycle count used for ready times
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + TIME_W'(1);
    end

    // Event counters for repeats, evictions and issues
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_hit   <= '0;
            cnt_evict <= '0;
            cnt_issue <= '0;
        end else begin
            if (act == ACT_PROMOTE || act == ACT_HIT) cnt_hit <= cnt_hit + CNT_W'(1);
            if (evict) cnt_evict <= cnt_evict + CNT_W'(1);
            if (pop)   cnt_issue <= cnt_issue + CNT_W'(1);
        end
    end

    // Stored array stays sorted and compacted
    for (genvar i = 0; i < DEPTH - 1; i++) begin : g_chk
        AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            q_v[i+1] |-> ($signed(q_w[i][PRIO_LO +: PRIO_W]) >= $signed(q_w[i+1][PRIO_LO +: PRIO_W]))); // R2
        AST_NO_HOLES: assert property (@(posedge clk) disable iff (!rst_n)
            q_v[i+1] |-> q_v[i]); // R2
    end

    AST_ROOM_BEFORE_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !v2[DEPTH-1]); // R8
    AST_EVICT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_evict != $past(cnt_evict)) |-> $past(q_v[DEPTH-1])); // R8
    AST_HIT_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && cfg_filter_en && scan_hit && !pop) |=> ($countones(q_v) == $past($countones(q_v)))); // R5
    AST_POP_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> (cnt_issue == $past(cnt_issue) + CNT_W'(1))); // R4
    AST_SWAP_SAME_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && act == ACT_NEW) |=> ($countones(q_v) == $past($countones(q_v)))); // R9

endmodule

// File: tb/test_prefetch_prio_queue.sv
// Bench for prefetch_prio_queue: a list-based behavioural model stepped
// every clock and compared against the ports at each falling edge.
module test_prefetch_prio_queue;

    localparam int DEPTH  = 8;
    localparam int BLK_W  = 26;
    localparam int PRIO_W = 8;
    localparam int LAT_W  = 4;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_filter_en = 1'b1;
    logic [LAT_W-1:0]  cfg_latency = 4'd1;
    logic              ins_valid = 1'b0;
    logic [BLK_W-1:0]  ins_blk = '0;
    logic              ins_secure = 1'b0;
    logic [PRIO_W-1:0] ins_prio = '0;
    logic              iss_valid;
    logic              iss_ready = 1'b0;
    logic [BLK_W-1:0]  iss_blk;
    logic              iss_secure;
    logic [PRIO_W-1:0] iss_prio;
    logic [CNT_W-1:0]  cnt_hit, cnt_evict, cnt_issue;

    always #10 clk = ~clk;

    prefetch_prio_queue #(
        .DEPTH(DEPTH), .BLK_W(BLK_W), .PRIO_W(PRIO_W), .LAT_W(LAT_W), .CNT_W(CNT_W)
    ) i_prefetch_prio_queue (
        .clk(clk), .rst_n(rst_n), .cfg_filter_en(cfg_filter_en), .cfg_latency(cfg_latency),
        .ins_valid(ins_valid), .ins_blk(ins_blk), .ins_secure(ins_secure), .ins_prio(ins_prio),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_blk(iss_blk),
        .iss_secure(iss_secure), .iss_prio(iss_prio),
        .cnt_hit(cnt_hit), .cnt_evict(cnt_evict), .cnt_issue(cnt_issue)
    );

    typedef struct {
        int blk;
        bit sec;
        int prio;
        int rdy;
    } m_ent_t;

    m_ent_t mq[$];
    int     now_m = 0;
    int     m_hit = 0, m_ev = 0, m_iss = 0;
    int     vectors = 0, errors = 0;
    bit     ended = 1'b0;
    string  cur_req = "R1";

    function automatic bit model_valid();
        return (mq.size() > 0) && (now_m >= mq[0].rdy);
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    task automatic check_int(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every observable port with the model
    task automatic compare_all();
        bit mv = model_valid();
        check_int("iss_valid", int'(iss_valid), int'(mv));
        if (mv) begin
            check_int("iss_blk", int'(iss_blk), mq[0].blk);
            check_int("iss_secure", int'(iss_secure), int'(mq[0].sec));
            check_int("iss_prio", int'($signed(iss_prio)), mq[0].prio);
        end
        check_int("cnt_hit", int'(cnt_hit), m_hit);
        check_int("cnt_evict", int'(cnt_evict), m_ev);
        check_int("cnt_issue", int'(cnt_issue), m_iss);
    endtask

    // Place by the ordering rule: behind all entries of equal or higher priority
    task automatic model_place(m_ent_t e);
        int p = mq.size();
        for (int k = 0; k < mq.size(); k++) begin
            if (mq[k].prio < e.prio) begin
                p = k;
                break;
            end
        end
        mq.insert(p, e);
    endtask

    // One clock: drive, update the model at the edge, compare after it
    task automatic step(bit iv, int blk, bit sec, int prio, bit rq);
        bit do_pop;
        ins_valid  = iv;
        ins_blk    = BLK_W'(blk);
        ins_secure = sec;
        ins_prio   = PRIO_W'(prio);
        iss_ready  = rq;
        do_pop = rq && model_valid();
        @(posedge clk);
        if (do_pop) begin
            mq.delete(0);
            m_iss++;
        end
        if (iv) begin
            int f = -1;
            if (cfg_filter_en) begin
                for (int k = 0; k < mq.size(); k++) begin
                    if (mq[k].blk == blk && mq[k].sec == sec) begin
                        f = k;
                        break;
                    end
                end
            end
            if (f >= 0) begin
                m_hit++;
                if (prio > mq[f].prio) begin
                    m_ent_t e = mq[f];
                    e.prio = prio;
                    mq.delete(f);
                    model_place(e);
                end
            end else begin
                m_ent_t e;
                e.blk = blk; e.sec = sec; e.prio = prio; e.rdy = now_m + int'(cfg_latency);
                if (mq.size() == DEPTH) begin
                    int lo = mq[mq.size()-1].prio;
                    int v = 0;
                    while (mq[v].prio != lo) v++;
                    mq.delete(v);
                    m_ev++;
                end
                model_place(e);
            end
        end
        now_m++;
        @(negedge clk);
        ins_valid = 1'b0;
        iss_ready = 1'b0;
        compare_all();
    endtask

    task automatic idle(int n, bit rq);
        for (int k = 0; k < n; k++) step(1'b0, 0, 1'b0, 0, rq);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare_all();
        rst_n = 1'b1;
        now_m = 0;

        // R3: latency 3 and latency 0 timing
        cur_req = "R3";
        cfg_latency = 4'd3;
        step(1'b1, 100, 1'b0, 0, 1'b1);
        idle(5, 1'b1);
        cfg_latency = 4'd0;
        step(1'b1, 101, 1'b1, 4, 1'b1);
        idle(2, 1'b1);

        // R2: mixed priorities, then ties, drained in order
        cur_req = "R2";
        step(1'b1, 1, 1'b0, 5, 1'b0);
        step(1'b1, 2, 1'b0, 2, 1'b0);
        step(1'b1, 3, 1'b0, 5, 1'b0);
        step(1'b1, 4, 1'b0, 7, 1'b0);
        step(1'b1, 5, 1'b0, -2, 1'b0);
        step(1'b1, 6, 1'b0, 2, 1'b0);
        cur_req = "R4";
        idle(7, 1'b1);

        // R5: repeats with equal and lower priority, incl. secure-bit distinction
        cur_req = "R5";
        step(1'b1, 10, 1'b0, 3, 1'b0);
        step(1'b1, 11, 1'b0, 3, 1'b0);
        step(1'b1, 10, 1'b0, 3, 1'b0);
        step(1'b1, 10, 1'b0, -1, 1'b0);
        step(1'b1, 10, 1'b1, 3, 1'b0);

        // R6: repeat with higher priority moves ahead
        cur_req = "R6";
        step(1'b1, 12, 1'b0, 1, 1'b0);
        step(1'b1, 12, 1'b0, 3, 1'b0);
        step(1'b1, 11, 1'b0, 9, 1'b0);
        idle(7, 1'b1);

        // R7: filter off stores repeats
        cur_req = "R7";
        cfg_filter_en = 1'b0;
        step(1'b1, 20, 1'b0, 1, 1'b0);
        step(1'b1, 20, 1'b0, 1, 1'b0);
        step(1'b1, 20, 1'b0, 6, 1'b0);
        idle(4, 1'b1);
        cfg_filter_en = 1'b1;

        // R8: full queue evicts oldest lowest, incl. a below-all newcomer
        cur_req = "R8";
        for (int k = 0; k < DEPTH; k++) step(1'b1, 30 + k, 1'b0, 4 - (k / 3), 1'b0);
        step(1'b1, 50, 1'b0, 3, 1'b0);
        step(1'b1, 51, 1'b0, -5, 1'b0);
        step(1'b1, 52, 1'b0, -5, 1'b0);
        step(1'b1, 53, 1'b0, 8, 1'b0);

        // R9: insert while full and issuing; repeat of the head being issued
        cur_req = "R9";
        step(1'b1, 60, 1'b0, 0, 1'b1);
        step(1'b1, 30, 1'b0, 9, 1'b1);
        step(1'b1, 61, 1'b0, 1, 1'b1);
        idle(10, 1'b1);

        // Random traffic over few blocks, checks R2 with all rules active
        cur_req = "R2";
        for (int n = 0; n < 600; n++) begin
            if (n % 97 == 0) cfg_filter_en = ($urandom % 4) != 0;
            if (n % 53 == 0) cfg_latency = LAT_W'($urandom % 4);
            step(($urandom % 10) < 7, int'($urandom % 12), bit'($urandom % 2),
                 int'($urandom % 7) - 3, ($urandom % 10) < 4);
        end
        idle(DEPTH + 6, 1'b1);

        finish_run();
    end

endmodule